// File: doc/BRIEF.md
# Auxiliary Timestamp Snapshot Unit

The unit watches four asynchronous trigger pins and records the value of a free-running seconds/nanoseconds time base whenever an enabled pin rises. Each pin passes through a two-stage synchroniser, and the rising edge is found on the synchronised level. The recorded time and a mask of the pins that caused it go into a four-entry queue. Software drains the queue through a small register port.

Software sets a per-pin enable in the control register and waits for the interrupt. It reads the status word to learn which pins fired. It then reads the nanoseconds word and then the seconds word, and reading the seconds word retires the entry. Pins that rise on the same sampled cycle share one entry. When the queue is full, new events are dropped and the loss is recorded in a sticky flag.

Top module: `aux_snap_unit`

## Requirements
- R1: A rising edge on an enabled trigger input stores one entry holding the `time_ns_i` and `time_sec_i` values present two to three cycles after the edge, and sets status bit 0 (entry available).
- R2: Control register 0x700 bits 25, 26, 27 and 28 enable inputs 0, 1, 2 and 3. An edge on a disabled input stores nothing and sets no source bit.
- R3: Status register 0x728 bits 19:16 give the source mask of the head entry, with bit 16+i set for input i. Edges detected on the same cycle share a single entry with all of their bits set.
- R4: The queue holds 4 entries. When it is full, a new event is discarded and the stored entries are unchanged.
- R5: Status bit 3 is set when an event is discarded and stays set until the status register is read. The read that clears it still returns 1.
- R6: Offset 0x730 returns the head nanoseconds and 0x734 the head seconds. Only a read of 0x734 removes the head, and entries leave in arrival order.
- R7: Writing 1 to control bit 24 empties the queue. That bit always reads back 0, and the enable bits take the value written in the same access.
- R8: `irq_o` is high when an entry is available and mask register 0x738 bit 0 is 0. Setting that bit to 1 forces `irq_o` low without affecting the queue.
- R9: After reset the queue is empty, `irq_o` is low, and the control, status and mask registers read 0.
- R10: A trigger held high for many cycles produces exactly one entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| trig_i | input | 4 | Asynchronous trigger pins |
| time_sec_i | input | 32 | Time base, seconds |
| time_ns_i | input | 32 | Time base, nanoseconds |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe (read side effects) |
| reg_addr_i | input | 12 | Register byte offset |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i` (combinational) |
| irq_o | output | 1 | Snapshot-ready interrupt |

## Verification
The capture path is driven with single pins, with pairs of pins rising together, with all four pins rising while only some are enabled, and with all four pins rising while none is enabled. These cases separate a correct source mask from one that merges or drops pins, and they confirm that the enable gates the capture. A burst of five events into the four-entry queue shows whether the oldest entries survive and whether the fifth is lost. This burst also exercises the overflow flag being set and then cleared by a read. A trigger held high for a long time, a clear command, and the interrupt mask each have a directed case.

// File: rtl/aux_snap_pkg.sv
package aux_snap_pkg;
  localparam int unsigned ADDR_W = 12;
  localparam int unsigned DATA_W = 32;

  localparam logic [ADDR_W-1:0] OFS_CTRL = 12'h700;
  localparam logic [ADDR_W-1:0] OFS_STAT = 12'h728;
  localparam logic [ADDR_W-1:0] OFS_NS   = 12'h730;
  localparam logic [ADDR_W-1:0] OFS_SEC  = 12'h734;
  localparam logic [ADDR_W-1:0] OFS_MASK = 12'h738;

  localparam int unsigned CTRL_CLR_BIT  = 24;
  localparam int unsigned CTRL_EN_LSB   = 25;
  localparam int unsigned STAT_SRC_LSB  = 16;
  localparam int unsigned STAT_OVF_BIT  = 3;
  localparam int unsigned STAT_AVL_BIT  = 0;
endpackage

// File: rtl/aux_trig_sync.sv
module aux_trig_sync #(
  parameter int unsigned NUM_TRIG = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_TRIG-1:0] trig_i,
  output logic [NUM_TRIG-1:0] rise_o
);
  for (genvar i = 0; i < NUM_TRIG; i++) begin : g_ch
    logic s1_q, s2_q, prev_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q   <= 1'b0;
        s2_q   <= 1'b0;
        prev_q <= 1'b0;
      end else begin
        s1_q   <= trig_i[i];
        s2_q   <= s1_q;
        prev_q <= s2_q;
      end
    end
    assign rise_o[i] = s2_q & ~prev_q;
  end
endmodule

// File: rtl/aux_snap_fifo.sv
module aux_snap_fifo #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 4,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [W-1:0]  din_i,
  output logic [W-1:0]  head_o,
  output logic          empty_o,
  output logic          full_o,
  output logic          drop_o,
  output logic [CW-1:0] count_o
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt;
  logic          push_ok, pop_ok;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign empty_o = (cnt == '0);
  assign full_o  = (cnt == CW'(DEPTH));
  // clear has priority over both push and pop; a full queue never accepts
  assign push_ok = push_i & ~full_o & ~clr_i;
  assign pop_ok  = pop_i & ~empty_o & ~clr_i;
  assign drop_o  = push_i & full_o & ~clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else if (clr_i) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push_ok) wr_ptr <= nxt(wr_ptr);
      if (pop_ok)  rd_ptr <= nxt(rd_ptr);
      case ({push_ok, pop_ok})
        2'b10:   cnt <= cnt + CW'(1);
        2'b01:   cnt <= cnt - CW'(1);
        default: cnt <= cnt;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_ok) mem[wr_ptr] <= din_i;
  end

  assign head_o  = mem[rd_ptr];
  assign count_o = cnt;
endmodule

// File: rtl/aux_snap_unit.sv
module aux_snap_unit
  import aux_snap_pkg::*;
#(
  parameter int unsigned NUM_TRIG   = 4,
  parameter int unsigned FIFO_DEPTH = 4,
  parameter int unsigned TIME_W     = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_TRIG-1:0] trig_i,
  input  logic [TIME_W-1:0]   time_sec_i,
  input  logic [TIME_W-1:0]   time_ns_i,
  input  logic                reg_we_i,
  input  logic                reg_re_i,
  input  logic [ADDR_W-1:0]   reg_addr_i,
  input  logic [DATA_W-1:0]   reg_wdata_i,
  output logic [DATA_W-1:0]   reg_rdata_o,
  output logic                irq_o
);
  localparam int unsigned ENT_W = NUM_TRIG + 2 * TIME_W;
  localparam int unsigned CNT_W = $clog2(FIFO_DEPTH + 1);

  logic [NUM_TRIG-1:0] rise, hit, en_q, head_src;
  logic [TIME_W-1:0]   head_sec, head_ns;
  logic [ENT_W-1:0]    head;
  logic [CNT_W-1:0]    fifo_cnt;
  logic                irq_mask_q, ovf_q;
  logic                push_req, pop_req, clr_cmd, stat_rd, ctrl_wr;
  logic                empty, full, drop;
  logic                unused_wdata;

  aux_trig_sync #(.NUM_TRIG(NUM_TRIG)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .trig_i (trig_i),
    .rise_o (rise)
  );

  assign hit      = rise & en_q;
  assign push_req = |hit;
  assign ctrl_wr  = reg_we_i && (reg_addr_i == OFS_CTRL);
  assign clr_cmd  = ctrl_wr && reg_wdata_i[CTRL_CLR_BIT];
  assign pop_req  = reg_re_i && (reg_addr_i == OFS_SEC);
  assign stat_rd  = reg_re_i && (reg_addr_i == OFS_STAT);

  aux_snap_fifo #(.W(ENT_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (clr_cmd),
    .push_i  (push_req),
    .pop_i   (pop_req),
    .din_i   ({hit, time_sec_i, time_ns_i}),
    .head_o  (head),
    .empty_o (empty),
    .full_o  (full),
    .drop_o  (drop),
    .count_o (fifo_cnt)
  );

  assign {head_src, head_sec, head_ns} = head;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q       <= '0;
      irq_mask_q <= 1'b0;
      ovf_q      <= 1'b0;
    end else begin
      if (ctrl_wr) en_q <= reg_wdata_i[CTRL_EN_LSB +: NUM_TRIG];
      if (reg_we_i && (reg_addr_i == OFS_MASK)) irq_mask_q <= reg_wdata_i[0];
      // a drop in the same cycle as the clearing read wins
      if (drop)         ovf_q <= 1'b1;
      else if (stat_rd) ovf_q <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      OFS_CTRL: reg_rdata_o[CTRL_EN_LSB +: NUM_TRIG] = en_q;
      OFS_STAT: begin
        if (!empty) reg_rdata_o[STAT_SRC_LSB +: NUM_TRIG] = head_src;
        reg_rdata_o[STAT_OVF_BIT] = ovf_q;
        reg_rdata_o[STAT_AVL_BIT] = ~empty;
      end
      OFS_NS:   if (!empty) reg_rdata_o = DATA_W'(head_ns);
      OFS_SEC:  if (!empty) reg_rdata_o = DATA_W'(head_sec);
      OFS_MASK: reg_rdata_o[0] = irq_mask_q;
      default:  reg_rdata_o = '0;
    endcase
  end

  assign irq_o = ~empty & ~irq_mask_q;
  assign unused_wdata = ^{reg_wdata_i, full};
endmodule

// File: rtl/aux_snap_chk.sv
module aux_snap_chk #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned CW    = 3
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          irq_o,
  input logic [CW-1:0] fifo_cnt,
  input logic          ovf_q,
  input logic          push_req,
  input logic          pop_req,
  input logic          clr_cmd,
  input logic          stat_rd
);
  a_r9_irq_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_cnt == '0) |-> !irq_o);

  a_r4_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_cnt <= CW'(DEPTH));

  a_r4_full_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_cnt == CW'(DEPTH) && !pop_req && !clr_cmd) |=> (fifo_cnt == CW'(DEPTH)));

  a_r5_ovf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_q && !stat_rd) |=> ovf_q);

  a_r7_clear_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_cmd |=> (fifo_cnt == '0));

  a_r6_pop_dec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_req && fifo_cnt != '0 && !push_req && !clr_cmd)
      |=> (fifo_cnt == $past(fifo_cnt) - CW'(1)));

  a_r1_push_inc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_req && fifo_cnt < CW'(DEPTH) && !pop_req && !clr_cmd)
      |=> (fifo_cnt == $past(fifo_cnt) + CW'(1)));
endmodule

bind aux_snap_unit aux_snap_chk #(.DEPTH(FIFO_DEPTH), .CW(CNT_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .irq_o    (irq_o),
  .fifo_cnt (fifo_cnt),
  .ovf_q    (ovf_q),
  .push_req (push_req),
  .pop_req  (pop_req),
  .clr_cmd  (clr_cmd),
  .stat_rd  (stat_rd)
);

// File: tb/tb_aux_snap_unit.sv
module tb_aux_snap_unit;
  localparam logic [11:0] A_CTRL = 12'h700, A_STAT = 12'h728, A_NS = 12'h730,
                          A_SEC = 12'h734, A_MASK = 12'h738;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  trig = '0;
  logic [31:0] tsec = '0, tns = '0;
  logic        we = 1'b0, re = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int          checks = 0, errors = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  aux_snap_unit dut (
    .clk_i(clk), .rst_ni(rst_n), .trig_i(trig), .time_sec_i(tsec), .time_ns_i(tns),
    .reg_we_i(we), .reg_re_i(re), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq)
  );

  typedef struct packed {
    logic [3:0]  en;
    logic [3:0]  pins;
    logic [3:0]  src;
    logic [31:0] sec;
    logic [31:0] ns;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{4'hF, 4'h1, 4'h1, 32'd11, 32'd1000},
    '{4'hF, 4'h4, 4'h4, 32'd22, 32'd2000},
    '{4'hF, 4'h9, 4'h9, 32'd33, 32'd3000},
    '{4'h5, 4'hF, 4'h5, 32'd44, 32'd4000},
    '{4'h0, 4'hF, 4'h0, 32'd55, 32'd5000},
    '{4'h8, 4'h8, 4'h8, 32'd66, 32'd999999999}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; re = 1'b1; #1 d = rdata;
    @(negedge clk); re = 1'b0;
  endtask

  task automatic fire(input logic [3:0] p, input int hold);
    @(negedge clk); trig = p;
    repeat (hold) @(negedge clk);
    trig = '0;
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R9 reset state
    check("R9 irq", {31'd0, irq}, 32'd0);
    rd(A_STAT, v); check("R9 status", v, 32'd0);
    rd(A_CTRL, v); check("R9 ctrl", v, 32'd0);
    rd(A_MASK, v); check("R9 mask", v, 32'd0);

    // R1 R2 R3 R6 vector walk
    foreach (VECS[i]) begin
      wr(A_CTRL, {3'd0, VECS[i].en, 25'd0});
      tsec = VECS[i].sec; tns = VECS[i].ns;
      fire(VECS[i].pins, 4);
      rd(A_STAT, v);
      check("R1/R2/R3 status", v, {12'd0, VECS[i].src, 15'd0, (VECS[i].src != 0)});
      if (VECS[i].src != 0) begin
        rd(A_NS, v);  check("R1/R6 ns", v, VECS[i].ns);
        rd(A_SEC, v); check("R1/R6 sec", v, VECS[i].sec);
        rd(A_STAT, v); check("R6 empty after pop", v, 32'd0);
      end
    end

    // R10 held level gives one entry
    wr(A_CTRL, {3'd0, 4'h2, 25'd0});
    tsec = 32'd77; tns = 32'd7;
    fire(4'h2, 30);
    rd(A_SEC, v);  check("R10 sec", v, 32'd77);
    rd(A_STAT, v); check("R10 only one entry", v, 32'd0);

    // R4 R5 R6 R8 overflow burst
    wr(A_CTRL, {3'd0, 4'hF, 25'd0});
    for (int k = 0; k < 5; k++) begin
      tsec = 32'd100 + 32'(k); tns = 32'd500 + 32'(k);
      fire(4'h1, 3);
    end
    check("R8 irq pending", {31'd0, irq}, 32'd1);
    rd(A_STAT, v); check("R5 overflow set", v, 32'h0001_0009);
    rd(A_STAT, v); check("R5 overflow cleared", v, 32'h0001_0001);
    for (int k = 0; k < 4; k++) begin
      rd(A_NS, v);  check("R6 ns", v, 32'd500 + 32'(k));
      rd(A_NS, v);  check("R6 ns no pop", v, 32'd500 + 32'(k));
      rd(A_SEC, v); check("R4/R6 sec order", v, 32'd100 + 32'(k));
    end
    rd(A_STAT, v); check("R4 fifth dropped", v, 32'd0);
    check("R8 irq idle", {31'd0, irq}, 32'd0);

    // R7 clear command
    tsec = 32'd200; fire(4'h4, 3);
    tsec = 32'd201; fire(4'h8, 3);
    wr(A_CTRL, {3'd0, 4'hA, 1'b1, 24'd0});
    rd(A_STAT, v); check("R7 cleared", v, 32'd0);
    rd(A_CTRL, v); check("R7 ctrl readback", v, {3'd0, 4'hA, 25'd0});

    // R8 interrupt mask
    tsec = 32'd300; tns = 32'd30;
    fire(4'h8, 3);
    wr(A_MASK, 32'd1);
    check("R8 masked irq", {31'd0, irq}, 32'd0);
    rd(A_STAT, v); check("R8 masked still available", v, 32'h0008_0001);
    wr(A_MASK, 32'd0);
    check("R8 unmasked irq", {31'd0, irq}, 32'd1);
    rd(A_SEC, v); check("R8 sec", v, 32'd300);
    check("R8 irq after drain", {31'd0, irq}, 32'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule